// File: doc/BRIEF.md
# Asynchronous SRAM Write-Timing Monitor

This block sits beside the control, address and data lines of an asynchronous static RAM and watches them without driving anything. A free-running clock of known period samples the lines. Every interval is measured as a count of samples and compared with a minimum limit given in nanoseconds. The limit is rounded up to whole sample periods, so with the default 5 ns sample period the limits are 9 samples for the write pulse, 9 for address setup, 5 for data setup and 11 for cycle time.

A write window is open on each sample where chip enable (`ce_n`) and write enable (`we_n`) are both low. The window opens on the later of the two falling edges and closes on the earlier of the two rising edges, so writes ended by either strobe are handled alike. When a window closes, the monitor judges the pulse width, the address setup and the data setup against the edge that ended the write. When a window opens, it judges the spacing from the previous start. On every sample inside the window it watches for address movement.

Each broken rule sets a sticky flag and adds to a saturating error count. A separate sticky warning marks a write that starts while output enable (`oe_n`) is low. A control state machine has three states:
- `MS_ARM` waits after reset.
- `MS_IDLE` waits for a window.
- `MS_WRITE` is inside a window.

It has three transitions:
- T_SETTLE (`MS_ARM` to `MS_IDLE`, on the first sample with no window).
- T_OPEN (`MS_IDLE` to `MS_WRITE`, the start sample).
- T_CLOSE (`MS_WRITE` to `MS_IDLE`, the end sample).

Top module: `sram_write_timing_mon`

## Requirements
- R1: At the end sample, the write window counts in-window samples. A count below ceil(PULSE_NS/SAMPLE_NS) sets `viol_flags[0]`. A count of exactly the limit does not set it.
- R2: At the end sample, the monitor counts the consecutive samples, up to the last in-window sample, over which `addr` held its value. A count below ceil(ADDR_SETUP_NS/SAMPLE_NS) sets `viol_flags[1]`.
- R3: At the end sample, the monitor counts the consecutive samples, up to the last in-window sample, over which `data` held its value. A count below ceil(DATA_SETUP_NS/SAMPLE_NS) sets `viol_flags[2]`.
- R4: At each start sample, the monitor takes the distance in samples from the previous start sample. A distance below ceil(CYCLE_NS/SAMPLE_NS) sets `viol_flags[3]`. The first start after arming has no previous start and is not judged.
- R5: A change of `addr` on any in-window sample after the start sample sets `viol_flags[4]`. A change on the start sample or on the end sample does not set it.
- R6: A start sample with `oe_n` low sets `contention_warn`, and this warning does not add to the error count. `oe_n` on any other sample has no effect.
- R7: Each sample adds its number of rule violations to `err_count`. The count saturates at all ones.
- R8: Flags, warning and count are sticky. A sample with `clr` high zeroes all of them, and `clr` takes priority over violations on that same sample.
- R9: After reset, all outputs are zero. A window already open when reset releases is not judged, and judging starts with the first start edge seen after a sample with no window.
- R10: A write ended by chip enable rising and a write ended by write enable rising give identical results for identical sample timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, period SAMPLE_NS |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of flags, warning and count |
| ce_n | input | 1 | Observed chip enable, active low |
| we_n | input | 1 | Observed write enable, active low |
| oe_n | input | 1 | Observed output enable, active low |
| addr | input | AW | Observed address lines |
| data | input | DW | Observed data lines |
| viol_flags | output | 5 | Sticky rule flags: bit0 pulse, bit1 address setup, bit2 data setup, bit3 cycle, bit4 address change in window |
| contention_warn | output | 1 | Sticky warning for a write started with output enable low |
| err_count | output | ERR_W | Saturating count of rule violations |

## Verification
The bench drives the exact-limit cases for pulse width, setup and cycle spacing. A monitor that used a less-or-equal comparison, or that measured from the wrong edge, would flag these legal writes. It moves the address on the start sample and mid-window, and it ends windows with each strobe, which catches a monitor that keys only on write enable or that treats the start sample as inside the window. It also holds a window across reset release, where a monitor that does not arm would report a bogus short pulse. It then drives enough bad writes to push the count past its top, where an unguarded adder would wrap to a small value.

// File: rtl/sram_wmon_pkg.sv
package sram_wmon_pkg;

    typedef enum logic [1:0] {
        MS_ARM   = 2'd0,
        MS_IDLE  = 2'd1,
        MS_WRITE = 2'd2
    } mon_state_t;

    localparam int RULE_PW    = 0;
    localparam int RULE_ASU   = 1;
    localparam int RULE_DSU   = 2;
    localparam int RULE_CYC   = 3;
    localparam int RULE_AHOLD = 4;
    localparam int NUM_RULES  = 5;

    function automatic int ns_to_samples(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

endpackage

// File: rtl/bus_age_tracker.sv
module bus_age_tracker #(
    parameter int AW = 19,
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic [CW-1:0] addr_age,
    output logic [CW-1:0] data_age,
    output logic          addr_moved
);
    localparam logic [CW-1:0] AGE_TOP = '1;

    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          data_moved;

    assign addr_moved = (addr != addr_q);
    assign data_moved = (data != data_q);

    // Age = samples the held value has been seen, counting the latest one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            addr_age <= '0;
        end else begin
            addr_q <= addr;
            if (addr_moved)
                addr_age <= CW'(1);
            else if (addr_age != AGE_TOP)
                addr_age <= addr_age + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            data_age <= '0;
        end else begin
            data_q <= data;
            if (data_moved)
                data_age <= CW'(1);
            else if (data_age != AGE_TOP)
                data_age <= data_age + CW'(1);
        end
    end

    // R2
    age_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_moved |=> (addr_age == CW'(1)));

endmodule

// File: rtl/write_window_fsm.sv
module write_window_fsm
    import sram_wmon_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    output mon_state_t    state,
    output logic          start_evt,
    output logic          end_evt,
    output logic          have_prev,
    output logic [CW-1:0] win_len,
    output logic [CW-1:0] gap
);
    localparam logic [CW-1:0] CNT_TOP = '1;

    mon_state_t next_state;
    logic       win_now;

    assign win_now = !ce_n && !we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= MS_ARM;
        else
            state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            MS_ARM:   if (!win_now) next_state = MS_IDLE;   // T_SETTLE
            MS_IDLE:  if (win_now)  next_state = MS_WRITE;  // T_OPEN
            MS_WRITE: if (!win_now) next_state = MS_IDLE;   // T_CLOSE
            default:  next_state = MS_ARM;
        endcase
    end

    always_comb begin
        start_evt = (state == MS_IDLE)  &&  win_now;
        end_evt   = (state == MS_WRITE) && !win_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_len   <= '0;
            gap       <= '0;
            have_prev <= 1'b0;
        end else begin
            if (start_evt)
                win_len <= CW'(1);
            else if (state == MS_WRITE && win_now && win_len != CNT_TOP)
                win_len <= win_len + CW'(1);

            if (start_evt)
                gap <= CW'(1);
            else if (gap != CNT_TOP)
                gap <= gap + CW'(1);

            if (start_evt)
                have_prev <= 1'b1;
        end
    end

    // R1
    window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == MS_WRITE && win_len == CW'(1)));

    // R1
    window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt |=> (state == MS_IDLE));

endmodule

// File: rtl/violation_log.sv
module violation_log #(
    parameter int NR = 5,
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [NR-1:0] viol,
    input  logic          warn_evt,
    output logic [NR-1:0] flags,
    output logic          warn,
    output logic [EW-1:0] count
);
    localparam int SW = $clog2(NR + 1);

    logic [SW-1:0] n_hit;
    logic [EW:0]   sum_wide;

    always_comb begin
        n_hit = '0;
        for (int i = 0; i < NR; i++)
            n_hit = n_hit + {{(SW-1){1'b0}}, viol[i]};
        sum_wide = {1'b0, count} + {{(EW+1-SW){1'b0}}, n_hit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            warn  <= 1'b0;
            count <= '0;
        end else if (clr) begin
            flags <= '0;
            warn  <= 1'b0;
            count <= '0;
        end else begin
            flags <= flags | viol;
            warn  <= warn | warn_evt;
            count <= sum_wide[EW] ? '1 : sum_wide[EW-1:0];
        end
    end

    // R8
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && flags == '0 && !warn));

    // R8
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

    // R7
    count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count >= $past(count)));

    // R6
    warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && warn) |=> warn);

endmodule

// File: rtl/sram_write_timing_mon.sv
module sram_write_timing_mon
    import sram_wmon_pkg::*;
#(
    parameter int AW            = 19,
    parameter int DW            = 8,
    parameter int SAMPLE_NS     = 5,
    parameter int PULSE_NS      = 45,
    parameter int ADDR_SETUP_NS = 45,
    parameter int DATA_SETUP_NS = 25,
    parameter int CYCLE_NS      = 55,
    parameter int ERR_W         = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 ce_n,
    input  logic                 we_n,
    input  logic                 oe_n,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        data,
    output logic [NUM_RULES-1:0] viol_flags,
    output logic                 contention_warn,
    output logic [ERR_W-1:0]     err_count
);
    localparam int PW_S  = ns_to_samples(PULSE_NS, SAMPLE_NS);
    localparam int ASU_S = ns_to_samples(ADDR_SETUP_NS, SAMPLE_NS);
    localparam int DSU_S = ns_to_samples(DATA_SETUP_NS, SAMPLE_NS);
    localparam int CYC_S = ns_to_samples(CYCLE_NS, SAMPLE_NS);
    localparam int M1    = (PW_S > ASU_S) ? PW_S : ASU_S;
    localparam int M2    = (DSU_S > CYC_S) ? DSU_S : CYC_S;
    localparam int LIM_MAX = (M1 > M2) ? M1 : M2;
    localparam int CW    = $clog2(LIM_MAX + 2);

    localparam logic [CW-1:0] PW_LIM  = CW'(PW_S);
    localparam logic [CW-1:0] ASU_LIM = CW'(ASU_S);
    localparam logic [CW-1:0] DSU_LIM = CW'(DSU_S);
    localparam logic [CW-1:0] CYC_LIM = CW'(CYC_S);

    mon_state_t           state;
    logic                 start_evt, end_evt, have_prev;
    logic [CW-1:0]        win_len, gap, addr_age, data_age;
    logic                 addr_moved, win_now, warn_evt;
    logic [NUM_RULES-1:0] viol;

    assign win_now = !ce_n && !we_n;

    bus_age_tracker #(.AW(AW), .DW(DW), .CW(CW)) u_age (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data(data),
        .addr_age(addr_age), .data_age(data_age), .addr_moved(addr_moved)
    );

    write_window_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
        .state(state), .start_evt(start_evt), .end_evt(end_evt),
        .have_prev(have_prev), .win_len(win_len), .gap(gap)
    );

    always_comb begin
        viol             = '0;
        viol[RULE_PW]    = end_evt && (win_len  < PW_LIM);
        viol[RULE_ASU]   = end_evt && (addr_age < ASU_LIM);
        viol[RULE_DSU]   = end_evt && (data_age < DSU_LIM);
        viol[RULE_CYC]   = start_evt && have_prev && (gap < CYC_LIM);
        viol[RULE_AHOLD] = (state == MS_WRITE) && win_now && addr_moved;
        warn_evt         = start_evt && !oe_n;
    end

    violation_log #(.NR(NUM_RULES), .EW(ERR_W)) u_log (
        .clk(clk), .rst_n(rst_n), .clr(clr), .viol(viol), .warn_evt(warn_evt),
        .flags(viol_flags), .warn(contention_warn), .count(err_count)
    );

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_WRITE && win_now && addr_moved && !clr) |=> viol_flags[RULE_AHOLD]);

    // R6
    contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !oe_n && !clr) |=> contention_warn);

endmodule

// File: tb/sram_write_timing_mon_test.sv
`timescale 1ns/100ps
module sram_write_timing_mon_test;
    localparam real CLK_PERIOD = 5.0;
    localparam int  SAMPLE_NS  = 5;
    localparam int  AW = 19;
    localparam int  DW = 8;
    localparam int  EW = 8;
    localparam int  L_PW  = (45 + SAMPLE_NS - 1) / SAMPLE_NS;
    localparam int  L_ASU = (45 + SAMPLE_NS - 1) / SAMPLE_NS;
    localparam int  L_DSU = (25 + SAMPLE_NS - 1) / SAMPLE_NS;
    localparam int  L_CYC = (55 + SAMPLE_NS - 1) / SAMPLE_NS;
    localparam int  CNT_TOP = (1 << EW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic [4:0]    viol_flags;
    logic          contention_warn;
    logic [EW-1:0] err_count;

    int n_checks = 0, n_fail = 0;
    int smp = 0, last_start = 0;
    bit have_prev_m = 0;
    logic [4:0] exp_flags = '0;
    bit exp_warn = 0;
    int exp_cnt = 0;
    logic [AW-1:0] cur_addr = '0;
    logic [DW-1:0] cur_data = '0;
    bit done = 0;

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    sram_write_timing_mon #(.AW(AW), .DW(DW), .SAMPLE_NS(SAMPLE_NS), .ERR_W(EW)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .data(data), .viol_flags(viol_flags),
        .contention_warn(contention_warn), .err_count(err_count)
    );

    function automatic logic [4:0] rule_hits(input int pw, input int aa, input int da,
                                             input bit cyc, input bit ah);
        logic [4:0] h;
        h[0] = (pw < L_PW);
        h[1] = (aa < L_ASU);
        h[2] = (da < L_DSU);
        h[3] = cyc;
        h[4] = ah;
        return h;
    endfunction

    function automatic int sat_add(input int cur, input int add);
        return (cur + add > CNT_TOP) ? CNT_TOP : cur + add;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        @(posedge clk); #1;
        chk({"R1 pulse ", ctx},   int'(viol_flags[0]), int'(exp_flags[0]));
        chk({"R2 asetup ", ctx},  int'(viol_flags[1]), int'(exp_flags[1]));
        chk({"R3 dsetup ", ctx},  int'(viol_flags[2]), int'(exp_flags[2]));
        chk({"R4 cycle ", ctx},   int'(viol_flags[3]), int'(exp_flags[3]));
        chk({"R5 ahold ", ctx},   int'(viol_flags[4]), int'(exp_flags[4]));
        chk({"R6 warn ", ctx},    int'(contention_warn), int'(exp_warn));
        chk({"R7 count ", ctx},   int'(err_count), exp_cnt);
    endtask

    task automatic tick(input logic c, input logic w, input logic o,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; addr = a; data = d;
        smp++;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        smp++;
        @(negedge clk);
        clr = 1'b0;
        smp++;
        exp_flags = '0; exp_warn = 0; exp_cnt = 0;
    endtask

    task automatic do_write(input int pre, input int pw, input int a_age, input int d_age,
                            input bit ce_ctl, input bit contend, input int glitch,
                            input string ctx);
        logic [AW-1:0] na, ga, a;
        logic [DW-1:0] nd, d;
        logic c, w, o;
        bit inwin, cyc, ah;
        int p, start_idx, aa;
        logic [4:0] hits;
        na = cur_addr + 1'b1;
        ga = na ^ {{(AW-1){1'b0}}, 1'b1};
        nd = cur_data + 1'b1;
        p = pre;
        if (a_age - pw > p) p = a_age - pw;
        if (d_age - pw > p) p = d_age - pw;
        if (p < 1) p = 1;
        start_idx = 0;
        a = cur_addr;
        for (int i = -p; i <= pw; i++) begin
            inwin = (i >= 0) && (i < pw);
            a = (i >= pw - a_age) ? na : cur_addr;
            if (glitch > 0 && i >= glitch) a = ga;
            d = (i >= pw - d_age) ? nd : cur_data;
            if (ce_ctl) begin c = !inwin; w = 1'b0; end
            else        begin c = 1'b0;   w = !inwin; end
            o = (i == 0) ? !contend : !inwin;
            tick(c, w, o, a, d);
            if (i == 0) start_idx = smp;
        end
        cur_addr = a;
        cur_data = nd;
        aa  = (glitch > 0) ? pw - glitch : a_age;
        ah  = (glitch > 0) || (a_age < pw);
        cyc = have_prev_m && ((start_idx - last_start) < L_CYC);
        hits = rule_hits(pw, aa, d_age, cyc, ah);
        exp_flags = exp_flags | hits;
        exp_cnt = sat_add(exp_cnt, $countones(hits));
        if (contend) exp_warn = 1;
        have_prev_m = 1;
        last_start = start_idx;
        check_all(ctx);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [4:0] fl_we, fl_ce;
        int cnt_we, cnt_ce, seed;
        seed = $urandom(32'd1357);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) tick(1'b1, 1'b1, 1'b1, cur_addr, cur_data);

        // R9 reset state
        @(posedge clk); #1;
        chk("R9 reset flags", int'(viol_flags), 0);
        chk("R9 reset count", int'(err_count), 0);
        chk("R9 reset warn", int'(contention_warn), 0);

        // Clean writes, both end styles; oe_n low inside window only (R6 no effect)
        do_write(3, 10, 12, 6, 1'b0, 1'b0, 0, "clean we-end");
        do_write(2, 10, 12, 6, 1'b1, 1'b0, 0, "clean ce-end");
        // Exact limits, R1 R2 R3 boundary, gap exactly 11 follows
        do_write(4, 9, 9, 5, 1'b0, 1'b0, 0, "exact limits");
        do_write(1, 9, 9, 5, 1'b1, 1'b0, 0, "exact cycle");
        // Address changes on the start sample: legal (R5)
        do_write(3, 10, 10, 6, 1'b0, 1'b0, 0, "addr at start");
        // One below limits
        do_write(4, 8, 10, 6, 1'b0, 1'b0, 0, "short pulse");
        do_clear();
        do_write(4, 12, 12, 4, 1'b1, 1'b0, 0, "short dsetup");
        do_clear();
        do_write(4, 12, 8, 6, 1'b0, 1'b0, 0, "addr in window");
        do_clear();
        do_write(4, 12, 14, 6, 1'b0, 1'b0, 2, "glitch early");
        do_write(4, 12, 14, 6, 1'b1, 1'b0, 5, "glitch late");
        do_clear();
        do_write(2, 7, 7, 3, 1'b0, 1'b0, 0, "short cycle a");
        do_write(1, 7, 7, 3, 1'b0, 1'b0, 0, "short cycle b");
        do_clear();
        do_write(4, 10, 12, 6, 1'b0, 1'b1, 0, "contention");
        // R8 clear
        do_clear();
        @(posedge clk); #1;
        chk("R8 clear flags", int'(viol_flags), 0);
        chk("R8 clear warn", int'(contention_warn), 0);
        chk("R8 clear count", int'(err_count), 0);

        // R10 same timing, two end styles
        do_write(4, 8, 8, 4, 1'b0, 1'b0, 0, "r10 we");
        fl_we = viol_flags; cnt_we = int'(err_count);
        do_clear();
        do_write(4, 8, 8, 4, 1'b1, 1'b0, 0, "r10 ce");
        fl_ce = viol_flags; cnt_ce = int'(err_count);
        chk("R10 flags match", int'(fl_ce), int'(fl_we));
        chk("R10 count match", cnt_ce, cnt_we);
        do_clear();

        // R9 window held across reset release is not judged
        @(negedge clk);
        rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; smp++;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) tick(1'b0, 1'b0, 1'b1, cur_addr, cur_data);
        tick(1'b1, 1'b1, 1'b1, cur_addr, cur_data);
        exp_flags = '0; exp_warn = 0; exp_cnt = 0; have_prev_m = 0;
        check_all("reset mid window");
        chk("R9 unjudged window", int'(err_count), 0);
        do_write(3, 10, 12, 6, 1'b0, 1'b0, 0, "after rearm");

        // R7 saturation
        for (int k = 0; k < 70; k++)
            do_write(1, 3, 3, 1, k[0], 1'b0, 0, "saturate");
        chk("R7 saturated", int'(err_count), CNT_TOP);
        do_clear();

        // Random writes
        for (int k = 0; k < 60; k++) begin
            int pw, aa, da, pre, gl;
            bit cc, ct;
            pw  = 2 + int'($urandom % 13);
            aa  = pw + int'($urandom % 6);
            da  = 1 + int'($urandom % (pw + 3));
            pre = 1 + int'($urandom % 4);
            cc  = $urandom % 2;
            ct  = ($urandom % 8) == 0;
            gl  = (($urandom % 5) == 0) ? 1 + int'($urandom % (pw - 1)) : 0;
            do_write(pre, pw, aa, da, cc, ct, gl, "random");
            if (($urandom % 10) == 0) do_clear();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule